// File: doc/BRIEF.md
# DMA Trigger Prioritizer and Dispatcher

This block is the front end of a small DMA channel controller. Every channel has three ways to start: a hardware event, a chain trigger from a completed transfer, and a software manual set. Each source has its own pending flag for every channel. Each cycle the block chooses one pending trigger and writes a queue entry. An entry holds the channel number and a source tag. It goes into one of two event queues, and a per-channel queue-select register picks which one.

On the output side, queue 0 drives transfer-controller port 0 and queue 1 drives port 1. Both ports use a valid/ready handshake. Queue 0 always has precedence. Queue 1 is held off whenever queue 0 holds any entry, even when controller 0 is stalled and controller 1 could accept work. System software should therefore keep queue 0 for short, urgent transfers.

Top module: `dma_trig_dispatch`

## Requirements
- R1: An active-low reset empties both queues and clears all pending flags, all sticky miss bits and every queue-select bit. After reset both port valids are low, and every channel routes to queue 0.
- R2: A one-cycle high on bit n of `evtIn`, `chainIn` or `manIn` sets the matching pending flag of channel n. Each set flag later yields exactly one queue entry.
- R3: When several flags of one channel are pending, they are queued as separate entries. The event entry comes first, then the chain entry, then the manual entry. The source tag is 0 for event, 1 for chain and 2 for manual, and the value 3 never appears.
- R4: Among channels that have a pending flag and room in their target queue, the lowest-numbered channel is served first. At most one entry is written per cycle.
- R5: `qSelData` is written into the queue-select register while `qSelWe` is high. A channel whose select bit is 0 is served on port 0, and one whose bit is 1 is served on port 1 only.
- R6: `tc1Valid` stays low while queue 0 is non-empty, whatever the state of `tc0Ready` and `tc1Ready`.
- R7: An entry leaves its queue only on a cycle where that port's valid and ready are both high. While ready is low, the presented channel and source stay stable.
- R8: A pending flag is cleared in the same cycle its entry is written. A trigger pulsed into an empty system is presented at its port two clock edges after the pulse is sampled, and not one edge after.
- R9: A trigger that arrives on a flag that is already set and not being cleared that cycle creates no extra entry. It sets the sticky miss bit `missOut[n]`, which then stays set until reset.
- R10: Each queue holds 8 entries. When a channel's target queue is full, its flags stay pending and are queued later with no loss and no change of source order. Channels that target the other queue continue to be served meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset |
| evtIn | input | NUM_CH | Hardware event pulses, one bit per channel |
| chainIn | input | NUM_CH | Chain trigger pulses, one bit per channel |
| manIn | input | NUM_CH | Manual (software) set pulses, one bit per channel |
| qSelWe | input | 1 | Write strobe for the queue-select register |
| qSelData | input | NUM_CH | New queue-select value, bit n for channel n (0 = queue 0, 1 = queue 1) |
| tc0Valid | output | 1 | Port 0 has an entry |
| tc0Ready | input | 1 | Controller 0 accepts the entry |
| tc0Chan | output | CH_W | Channel number of the port 0 entry |
| tc0Src | output | 2 | Source tag of the port 0 entry |
| tc1Valid | output | 1 | Port 1 has an entry |
| tc1Ready | input | 1 | Controller 1 accepts the entry |
| tc1Chan | output | CH_W | Channel number of the port 1 entry |
| tc1Src | output | 2 | Source tag of the port 1 entry |
| missOut | output | NUM_CH | Sticky missed-trigger bits, one per channel |

## Verification
The hardest situations to reach are a full queue 0 while further triggers arrive, and a flag that is re-triggered before it can be drained. To create them, the bench holds `tc0Ready` low and sets eight flags with a single pulse. It then re-pulses a channel whose flags are stuck behind the full queue, which produces a miss. It also triggers a higher channel routed to queue 1 so it can overtake the blocked one. Draining then shows the retried entries in source order. Separately, the port 1 stall is forced by holding controller 0 not-ready and controller 1 ready for several cycles, with entries waiting in both queues.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  typedef enum logic [1:0] {
    SRC_EVT = 2'd0,
    SRC_CHN = 2'd1,
    SRC_MAN = 2'd2
  } srcTag_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       enqValid;
    logic       enqSel;
    logic [1:0] deqFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  // DEPTH is expected to be a power of two
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW:0]      wrPtr;
  logic [AW:0]      rdPtr;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign rdData = store[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wrEn && !full) wrPtr <= wrPtr + 1'b1;
      if (rdEn && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !full) store[wrPtr[AW-1:0]] <= wrData;
  end

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int QDEPTH = 8,
  parameter int CH_W   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   qSelWe,
  input  logic [NUM_CH-1:0]      qSelData,
  input  ctrlStrobe_t            strobe,
  input  logic [CH_W-1:0]        enqChan,
  input  srcTag_e                enqSrc,
  output logic [NUM_CH-1:0]      qSel,
  output logic [1:0]             qFull,
  output logic [1:0]             qEmpty,
  output logic [1:0][CH_W-1:0]   headChan,
  output logic [1:0][1:0]        headSrc
);
  localparam int EW = CH_W + 2;

  logic [EW-1:0] enqWord;
  assign enqWord = {enqChan, enqSrc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       qSel <= '0;
    else if (qSelWe) qSel <= qSelData;
  end

  for (genvar g = 0; g < 2; g++) begin : gQueue
    logic [EW-1:0] headWord;
    logic          wrHere;

    assign wrHere = strobe.enqValid && (strobe.enqSel == 1'(g));

    evt_fifo #(.WIDTH(EW), .DEPTH(QDEPTH)) fifoI (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrHere),
      .wrData (enqWord),
      .rdEn   (strobe.deqFire[g]),
      .rdData (headWord),
      .full   (qFull[g]),
      .empty  (qEmpty[g])
    );

    assign headChan[g] = headWord[EW-1:2];
    assign headSrc[g]  = headWord[1:0];
  end

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic [NUM_CH-1:0] chainIn,
  input  logic [NUM_CH-1:0] manIn,
  input  logic [NUM_CH-1:0] qSel,
  input  logic [1:0]        qFull,
  input  logic [1:0]        qEmpty,
  input  logic [1:0]        tcReady,
  output ctrlStrobe_t       strobe,
  output logic [CH_W-1:0]   enqChan,
  output srcTag_e           enqSrc,
  output logic [1:0]        tcValid,
  output logic [NUM_CH-1:0] missOut
);
  logic [NUM_CH-1:0] evtFlag, chnFlag, manFlag;
  logic [NUM_CH-1:0] anyFlag, eligible, pickHot;
  logic [NUM_CH-1:0] clrEvt, clrChn, clrMan, missHit;
  logic              found;
  logic [CH_W-1:0]   pick;

  assign anyFlag = evtFlag | chnFlag | manFlag;

  // a channel may enqueue only if its target queue has room
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      eligible[i] = anyFlag[i] && !qFull[qSel[i]];
    end
  end

  // lowest-numbered eligible channel wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        pick  = CH_W'(i);
      end
    end
  end

  // fixed source order within the winning channel
  always_comb begin
    if (evtFlag[pick])      enqSrc = SRC_EVT;
    else if (chnFlag[pick]) enqSrc = SRC_CHN;
    else                    enqSrc = SRC_MAN;
  end

  assign pickHot = found ? (NUM_CH'(1) << pick) : '0;
  assign clrEvt  = (enqSrc == SRC_EVT) ? pickHot : '0;
  assign clrChn  = (enqSrc == SRC_CHN) ? pickHot : '0;
  assign clrMan  = (enqSrc == SRC_MAN) ? pickHot : '0;
  assign enqChan = pick;

  assign missHit = (evtIn & evtFlag & ~clrEvt)
                 | (chainIn & chnFlag & ~clrChn)
                 | (manIn & manFlag & ~clrMan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag <= '0;
      chnFlag <= '0;
      manFlag <= '0;
      missOut <= '0;
    end else begin
      evtFlag <= (evtFlag & ~clrEvt) | evtIn;
      chnFlag <= (chnFlag & ~clrChn) | chainIn;
      manFlag <= (manFlag & ~clrMan) | manIn;
      missOut <= missOut | missHit;
    end
  end

  // queue 0 always drains before queue 1
  assign tcValid[0] = !qEmpty[0];
  assign tcValid[1] = !qEmpty[1] && qEmpty[0];

  assign strobe.enqValid = found;
  assign strobe.enqSel   = qSel[pick];
  assign strobe.deqFire  = tcValid & tcReady;

endmodule

// File: rtl/dma_trig_dispatch.sv
module dma_trig_dispatch
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int QDEPTH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic [NUM_CH-1:0] chainIn,
  input  logic [NUM_CH-1:0] manIn,
  input  logic              qSelWe,
  input  logic [NUM_CH-1:0] qSelData,
  output logic              tc0Valid,
  input  logic              tc0Ready,
  output logic [CH_W-1:0]   tc0Chan,
  output logic [1:0]        tc0Src,
  output logic              tc1Valid,
  input  logic              tc1Ready,
  output logic [CH_W-1:0]   tc1Chan,
  output logic [1:0]        tc1Src,
  output logic [NUM_CH-1:0] missOut
);
  ctrlStrobe_t           strobe;
  logic [CH_W-1:0]       enqChan;
  srcTag_e               enqSrc;
  logic [NUM_CH-1:0]     qSel;
  logic [1:0]            qFull, qEmpty, tcValid;
  logic [1:0][CH_W-1:0]  headChan;
  logic [1:0][1:0]       headSrc;

  trig_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .chainIn (chainIn),
    .manIn   (manIn),
    .qSel    (qSel),
    .qFull   (qFull),
    .qEmpty  (qEmpty),
    .tcReady ({tc1Ready, tc0Ready}),
    .strobe  (strobe),
    .enqChan (enqChan),
    .enqSrc  (enqSrc),
    .tcValid (tcValid),
    .missOut (missOut)
  );

  trig_datapath #(.NUM_CH(NUM_CH), .QDEPTH(QDEPTH), .CH_W(CH_W)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .qSelWe   (qSelWe),
    .qSelData (qSelData),
    .strobe   (strobe),
    .enqChan  (enqChan),
    .enqSrc   (enqSrc),
    .qSel     (qSel),
    .qFull    (qFull),
    .qEmpty   (qEmpty),
    .headChan (headChan),
    .headSrc  (headSrc)
  );

  assign tc0Valid = tcValid[0];
  assign tc1Valid = tcValid[1];
  assign tc0Chan  = headChan[0];
  assign tc1Chan  = headChan[1];
  assign tc0Src   = headSrc[0];
  assign tc1Src   = headSrc[1];

endmodule

// File: rtl/trig_dispatch_chk.sv
module trig_dispatch_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tc0Valid,
  input logic              tc0Ready,
  input logic [CH_W-1:0]   tc0Chan,
  input logic [1:0]        tc0Src,
  input logic              tc1Valid,
  input logic              tc1Ready,
  input logic [CH_W-1:0]   tc1Chan,
  input logic [1:0]        tc1Src,
  input logic [NUM_CH-1:0] missOut
);
  // R6
  q1_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    tc1Valid |-> !tc0Valid);

  // R7
  port0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tc0Valid && !tc0Ready) |=> (tc0Valid && $stable(tc0Chan) && $stable(tc0Src)));

  // R7
  port1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tc1Valid && !tc1Ready && !tc0Valid) |=> (tc1Valid && $stable(tc1Chan) && $stable(tc1Src)));

  // R3
  src_tag_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tc0Valid -> tc0Src != 2'd3) && (tc1Valid -> tc1Src != 2'd3));

  // R9
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((missOut & $past(missOut)) == $past(missOut)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!tc0Valid && !tc1Valid && missOut == '0));

endmodule

bind dma_trig_dispatch trig_dispatch_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .tc0Valid (tc0Valid),
  .tc0Ready (tc0Ready),
  .tc0Chan  (tc0Chan),
  .tc0Src   (tc0Src),
  .tc1Valid (tc1Valid),
  .tc1Ready (tc1Ready),
  .tc1Chan  (tc1Chan),
  .tc1Src   (tc1Src),
  .missOut  (missOut)
);

// File: tb/dma_trig_dispatch_test.sv
module dma_trig_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int EVT = 0, CHN = 1, MAN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] evtIn = '0, chainIn = '0, manIn = '0, qSelData = '0;
  logic qSelWe = 1'b0, tc0Ready = 1'b0, tc1Ready = 1'b0;
  logic tc0Valid, tc1Valid;
  logic [2:0] tc0Chan, tc1Chan;
  logic [1:0] tc0Src, tc1Src;
  logic [NCH-1:0] missOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_dispatch uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .chainIn(chainIn), .manIn(manIn),
    .qSelWe(qSelWe), .qSelData(qSelData),
    .tc0Valid(tc0Valid), .tc0Ready(tc0Ready), .tc0Chan(tc0Chan), .tc0Src(tc0Src),
    .tc1Valid(tc1Valid), .tc1Ready(tc1Ready), .tc1Chan(tc1Chan), .tc1Src(tc1Src),
    .missOut(missOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; evtIn = '0; chainIn = '0; manIn = '0; qSelWe = 1'b0;
    tc0Ready = 1'b0; tc1Ready = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one-cycle pulse; returns at the negedge after the sampling edge
  task automatic pulse(input logic [NCH-1:0] e, input logic [NCH-1:0] c, input logic [NCH-1:0] m);
    evtIn = e; chainIn = c; manIn = m;
    @(negedge clk);
    evtIn = '0; chainIn = '0; manIn = '0;
  endtask

  task automatic writeSel(input logic [NCH-1:0] v);
    qSelWe = 1'b1; qSelData = v;
    @(negedge clk);
    qSelWe = 1'b0;
  endtask

  // wait for an entry on port q, compare it, then accept it
  task automatic pop(input int q, input int ch, input int src, input string req);
    int n = 0;
    while (((q == 0) ? !tc0Valid : !tc1Valid) && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (q == 0) begin
      check(tc0Valid && tc0Chan == 3'(ch) && tc0Src == 2'(src), req,
            tc0Valid ? int'(tc0Chan) * 4 + int'(tc0Src) : -1, ch * 4 + src);
      tc0Ready = 1'b1;
    end else begin
      check(tc1Valid && tc1Chan == 3'(ch) && tc1Src == 2'(src), req,
            tc1Valid ? int'(tc1Chan) * 4 + int'(tc1Src) : -1, ch * 4 + src);
      tc1Ready = 1'b1;
    end
    @(negedge clk);
    tc0Ready = 1'b0; tc1Ready = 1'b0;
  endtask

  task automatic expectIdle(input string req);
    repeat (4) @(negedge clk);
    check(!tc0Valid && !tc1Valid, req, {tc1Valid, tc0Valid}, 0);
  endtask

  task automatic testReset();
    doReset();
    check(!tc0Valid && !tc1Valid, "R1 valids after reset", {tc1Valid, tc0Valid}, 0);
    check(missOut == '0, "R1 miss after reset", missOut, 0);
  endtask

  task automatic testSameChannel();
    pulse(8'h08, 8'h08, 8'h08);
    check(!tc0Valid, "R8 not valid one edge after trigger", tc0Valid, 0);
    @(negedge clk);
    check(tc0Valid, "R8 valid two edges after trigger", tc0Valid, 1);
    pop(0, 3, EVT, "R3 event first");
    pop(0, 3, CHN, "R3 chain second");
    pop(0, 3, MAN, "R3 manual third");
    expectIdle("R2 one entry per flag");
    check(missOut == '0, "R9 no miss on separate sources", missOut, 0);
  endtask

  task automatic testChannelOrder();
    pulse(8'h04, 8'h20, 8'h20);
    pop(0, 2, EVT, "R4 lowest channel first");
    pop(0, 5, CHN, "R4 then next channel chain");
    pop(0, 5, MAN, "R4 then next channel manual");
    expectIdle("R4 drained");
  endtask

  task automatic testRouting();
    writeSel(8'h40);
    pulse(8'h40, '0, '0);
    repeat (3) @(negedge clk);
    check(!tc0Valid, "R5 port 0 unused for channel 6", tc0Valid, 0);
    pop(1, 6, EVT, "R5 channel 6 on port 1");
    expectIdle("R5 drained");
  endtask

  task automatic testStall();
    pulse(8'h42, '0, '0);
    repeat (4) @(negedge clk);
    tc1Ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tc0Valid && !tc1Valid, "R6 port 1 stalled behind queue 0",
            {tc1Valid, tc0Valid}, 1);
    end
    tc1Ready = 1'b0;
    check(tc0Chan == 3'd1, "R7 head held without ready", tc0Chan, 1);
    pop(0, 1, EVT, "R6 queue 0 first");
    pop(1, 6, EVT, "R6 queue 1 after queue 0 drains");
    expectIdle("R6 drained");
  endtask

  task automatic testFullAndMiss();
    writeSel(8'h20);
    // eight entries fill queue 0
    pulse(8'h07, 8'h07, 8'h03);
    repeat (10) @(negedge clk);
    check(tc0Valid && tc0Chan == 3'd0, "R10 queue 0 head after fill", tc0Chan, 0);
    pulse(8'h10, '0, 8'h10);
    pulse(8'h20, '0, '0);
    @(negedge clk);
    pulse(8'h10, '0, '0);
    check(missOut == 8'h10, "R9 miss on retrigger of pending flag", missOut, 8'h10);
    for (int c = 0; c < 3; c++) begin
      pop(0, c, EVT, "R10 drain event");
      pop(0, c, CHN, "R10 drain chain");
      if (c < 2) pop(0, c, MAN, "R10 drain manual");
    end
    pop(0, 4, EVT, "R10 retried event");
    pop(0, 4, MAN, "R10 retried manual");
    pop(1, 5, EVT, "R10 other queue served while blocked");
    expectIdle("R9 no extra entry from missed trigger");
    check(missOut == 8'h10, "R9 miss stays set", missOut, 8'h10);
  endtask

  task automatic testResetConfig();
    writeSel(8'hFF);
    doReset();
    check(missOut == '0, "R1 miss cleared by reset", missOut, 0);
    pulse(8'h40, '0, '0);
    repeat (2) @(negedge clk);
    check(!tc1Valid, "R1 select cleared by reset", tc1Valid, 0);
    pop(0, 6, EVT, "R1 channel 6 back on port 0");
  endtask

  initial begin
    testReset();
    testSameChannel();
    testChannelOrder();
    testRouting();
    testStall();
    testFullAndMiss();
    testResetConfig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule